// File: doc/BRIEF.md
# Partial Register Write-Back Merger

This block sits at the end of an integer pipeline and decides what a 64-bit destination register holds after an instruction writes it. It takes the register's current contents and a right-justified result (from the ALU or a load), together with the width of the source value, the width of the destination view, an extension mode and a flag that selects the high-byte view of a legacy register. From these it forms the new 64-bit value.

Narrow views keep whatever sits above them. A 32-bit view clears the upper half. A 64-bit view replaces everything. Extension moves widen a byte, word or doubleword source into a wider view with zero or sign fill, and the width of the destination view still decides what happens above it.

Combinations that no instruction form produces are flagged as illegal, and the old contents pass through unchanged. The merged value is combinational. A single output register loads it when write-enable is high and clears to zero on reset.

Top module: `partial_reg_merge`

## Requirements
- R1: Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. With extension mode 0 (none) and equal source and destination sizes of 8 or 16 bits, only the low 8 or 16 bits take the result; bits above keep the old value.
- R2: With mode none and size 32, bits 31..0 take the result and bits 63..32 become zero, whatever the upper bits of the result are.
- R3: With mode none and size 64, all 64 bits take the result.
- R4: Mode 1 (zero) is legal only for a byte or word source and a strictly wider destination. The extended bits are zero.
- R5: Mode 2 (sign) is legal for any source strictly narrower than the destination. The extended bits copy the source's top bit.
- R6: An extension into a 16-bit destination leaves bits 63..16 unchanged.
- R7: An extension into a 32-bit destination clears bits 63..32.
- R8: With the high-byte flag set (legal only with mode none and both sizes 8), bits 15..8 take result bits 7..0 and every other bit keeps its old value.
- R9: Any other combination raises `illegal`, including mode 3, mode none with unequal sizes, and a destination not wider than the source for an extension. The merged value is then the old contents.
- R10: Reset clears `q` to zero. `q` loads the merged value one clock after `wr_en` is high and holds while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the merged value into `q` |
| old_val | input | 64 | Current register contents |
| res | input | 64 | Right-justified result or loaded value |
| src_sz | input | 2 | Source size code |
| dst_sz | input | 2 | Destination view size code |
| ext_mode | input | 2 | 0 none, 1 zero, 2 sign, 3 reserved |
| hi_byte | input | 1 | Write the bits 15..8 view |
| merged | output | 64 | Combinational new register value |
| illegal | output | 1 | Combination not allowed |
| q | output | 64 | Registered new register value |

## Verification
The bench feeds results with garbage in the bits above the source width. A merger that forgets to mask the source therefore leaks those bits into zero-extended or 32-bit outcomes. It pairs all-ones old values with 8- and 16-bit writes, so a design that clears instead of preserving shows zeros in the upper bits, and it checks 32-bit writes over all-ones, where a preserving design would leave ones. Sign cases use both negative and positive sources, which exposes fill taken from the wrong bit. Illegal combinations, such as a zero-extended doubleword or a high-byte write at 16 bits, must leave the old value, which catches a decoder that accepts them.

// File: rtl/partial_reg_merge.sv
module partial_reg_merge #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] res,
  input  logic [1:0]      src_sz,
  input  logic [1:0]      dst_sz,
  input  logic [1:0]      ext_mode,
  input  logic            hi_byte,
  output logic [XLEN-1:0] merged,
  output logic            illegal,
  output logic [XLEN-1:0] q
);
  localparam logic [1:0] EXT_NONE = 2'd0;
  localparam logic [1:0] EXT_ZERO = 2'd1;
  localparam logic [1:0] EXT_SIGN = 2'd2;

  logic            sgn;
  logic            legal;
  logic [XLEN-1:0] ext_val;
  logic [XLEN-1:0] wr_val;

  assign sgn = (ext_mode == EXT_SIGN);

  always_comb begin
    if (hi_byte)
      legal = (ext_mode == EXT_NONE) && (src_sz == 2'd0) && (dst_sz == 2'd0);
    else
      case (ext_mode)
        EXT_NONE: legal = (src_sz == dst_sz);
        EXT_ZERO: legal = (src_sz < dst_sz) && (src_sz < 2'd2);
        EXT_SIGN: legal = (src_sz < dst_sz);
        default:  legal = 1'b0;
      endcase
  end

  always_comb begin
    case (src_sz)
      2'd0:    ext_val = {{(XLEN-8){sgn & res[7]}},   res[7:0]};
      2'd1:    ext_val = {{(XLEN-16){sgn & res[15]}}, res[15:0]};
      2'd2:    ext_val = {{(XLEN-32){sgn & res[31]}}, res[31:0]};
      default: ext_val = res;
    endcase
  end

  always_comb begin
    case (dst_sz)
      2'd0:    wr_val = {old_val[XLEN-1:8], ext_val[7:0]};
      2'd1:    wr_val = {old_val[XLEN-1:16], ext_val[15:0]};
      2'd2:    wr_val = {{(XLEN-32){1'b0}}, ext_val[31:0]};
      default: wr_val = ext_val;
    endcase
  end

  assign illegal = ~legal;
  assign merged  = !legal ? old_val :
                   hi_byte ? {old_val[XLEN-1:16], res[7:0], old_val[7:0]} : wr_val;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= merged;
  end

  always_comb begin
    if (rst_n && !illegal && hi_byte)
      p_hibyte_keeps_low_r8: assert (merged[7:0] == old_val[7:0]);
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  p_illegal_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && illegal) |=> (q == $past(old_val)));

  p_dword_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal && dst_sz == 2'd2) |=> (q[XLEN-1:32] == '0));

  p_narrow_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal && dst_sz < 2'd2) |=> (q[XLEN-1:16] == $past(old_val[XLEN-1:16])));

  p_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal && ext_mode == EXT_SIGN && src_sz == 2'd2)
      |=> (q[XLEN-1:32] == {(XLEN-32){$past(res[31])}}));
endmodule

// File: tb/tb_partial_reg_merge.sv
module tb_partial_reg_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] old_val = '0;
  logic [63:0] res = '0;
  logic [1:0]  src_sz = '0;
  logic [1:0]  dst_sz = '0;
  logic [1:0]  ext_mode = '0;
  logic        hi_byte = 1'b0;
  logic [63:0] merged;
  logic        illegal;
  logic [63:0] q;

  int tests = 0;
  int fails = 0;

  partial_reg_merge dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .old_val(old_val),
    .res(res), .src_sz(src_sz), .dst_sz(dst_sz), .ext_mode(ext_mode),
    .hi_byte(hi_byte), .merged(merged), .illegal(illegal), .q(q));

  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic [63:0] old_v;
    logic [63:0] res_v;
    logic [1:0]  src;
    logic [1:0]  dst;
    logic [1:0]  ext;
    logic        hb;
    logic [63:0] exp_q;
    logic        exp_err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{8'd1,  64'hFFFFFFFF12345678, 64'h00000000000000AB, 2'd0, 2'd0, 2'd0, 1'b0, 64'hFFFFFFFF123456AB, 1'b0}, // R1 byte
    '{8'd1,  64'hFFFFFFFF12345678, 64'h000000000000BEEF, 2'd1, 2'd1, 2'd0, 1'b0, 64'hFFFFFFFF1234BEEF, 1'b0}, // R1 word
    '{8'd2,  64'hFFFFFFFF12345678, 64'h99999999CAFEF00D, 2'd2, 2'd2, 2'd0, 1'b0, 64'h00000000CAFEF00D, 1'b0}, // R2
    '{8'd3,  64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 2'd3, 2'd3, 2'd0, 1'b0, 64'h0123456789ABCDEF, 1'b0}, // R3
    '{8'd4,  64'hFFFFFFFFFFFFFFFF, 64'h11111111111111F0, 2'd0, 2'd3, 2'd1, 1'b0, 64'h00000000000000F0, 1'b0}, // R4 b->q
    '{8'd4,  64'hFFFFFFFFFFFFFFFF, 64'h000000002222FEDC, 2'd1, 2'd2, 2'd1, 1'b0, 64'h000000000000FEDC, 1'b0}, // R4 w->d
    '{8'd6,  64'hFFFFFFFFFFFFFFFF, 64'h0000000000003380, 2'd0, 2'd1, 2'd1, 1'b0, 64'hFFFFFFFFFFFF0080, 1'b0}, // R6 zero b->w
    '{8'd6,  64'hFFFFFFFF0000FEDC, 64'h00000000000000BA, 2'd0, 2'd1, 2'd2, 1'b0, 64'hFFFFFFFF0000FFBA, 1'b0}, // R6 sign b->w
    '{8'd7,  64'hFFFFFFFF0000FFBA, 64'h0000000000000054, 2'd0, 2'd2, 2'd2, 1'b0, 64'h0000000000000054, 1'b0}, // R7
    '{8'd5,  64'h0000000000000000, 64'h00000000FEDCBA98, 2'd2, 2'd3, 2'd2, 1'b0, 64'hFFFFFFFFFEDCBA98, 1'b0}, // R5 d->q
    '{8'd5,  64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFF7FFF, 2'd1, 2'd3, 2'd2, 1'b0, 64'h0000000000007FFF, 1'b0}, // R5 w->q pos
    '{8'd7,  64'hFFFFFFFFFFFFFFFF, 64'h0000000000008001, 2'd1, 2'd2, 2'd2, 1'b0, 64'h00000000FFFF8001, 1'b0}, // R7 w->d
    '{8'd8,  64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFF5A, 2'd0, 2'd0, 2'd0, 1'b1, 64'h0123456789AB5AEF, 1'b0}, // R8
    '{8'd9,  64'hAAAAAAAAAAAAAAAA, 64'h5555555555555555, 2'd0, 2'd2, 2'd0, 1'b0, 64'hAAAAAAAAAAAAAAAA, 1'b1}, // R9 none mismatch
    '{8'd9,  64'hAAAAAAAAAAAAAAAA, 64'h0000000080000000, 2'd2, 2'd3, 2'd1, 1'b0, 64'hAAAAAAAAAAAAAAAA, 1'b1}, // R9 zero d->q
    '{8'd9,  64'h1234123412341234, 64'h00000000FFFFFFFF, 2'd2, 2'd1, 2'd2, 1'b0, 64'h1234123412341234, 1'b1}, // R9 narrowing
    '{8'd9,  64'h5A5A5A5A5A5A5A5A, 64'h0000000000000011, 2'd0, 2'd3, 2'd3, 1'b0, 64'h5A5A5A5A5A5A5A5A, 1'b1}, // R9 mode 3
    '{8'd9,  64'h0F0F0F0F0F0F0F0F, 64'h00000000000000EE, 2'd1, 2'd1, 2'd0, 1'b1, 64'h0F0F0F0F0F0F0F0F, 1'b1}  // R9 hi at 16
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 reset q", q, 64'h0);
    rst_n = 1'b1;
    foreach (VEC[i]) begin
      @(negedge clk);
      old_val = VEC[i].old_v; res = VEC[i].res_v; src_sz = VEC[i].src;
      dst_sz = VEC[i].dst; ext_mode = VEC[i].ext; hi_byte = VEC[i].hb; wr_en = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d q", VEC[i].req, i), q, VEC[i].exp_q);
      check($sformatf("R%0d vec%0d illegal", VEC[i].req, i), {63'h0, illegal}, {63'h0, VEC[i].exp_err});
    end
    // R10: hold while wr_en low
    @(negedge clk);
    wr_en = 1'b1; old_val = 64'h0; res = 64'hDEADBEEFDEADBEEF;
    src_sz = 2'd3; dst_sz = 2'd3; ext_mode = 2'd0; hi_byte = 1'b0;
    @(negedge clk);
    check("R3 load before hold", q, 64'hDEADBEEFDEADBEEF);
    wr_en = 1'b0; res = 64'h1111111111111111;
    repeat (3) @(negedge clk);
    check("R10 hold q", q, 64'hDEADBEEFDEADBEEF);
    check("R10 merged live", merged, 64'h1111111111111111);
    // R10: reset clears loaded value
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset again", q, 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule